// File: doc/BRIEF.md
# Serial Programming Entry Sequencer

This block sits on the programmer side of a serial programming link. It puts a target device into its serial programming state. After its own reset it holds the target's reset line and the serial clock low. A start request then begins an attempt. Each attempt raises the target reset for a short pulse and then waits a settling time, which is given as a cycle count. After that it shifts out a four-byte enable instruction in SPI mode 0, most significant bit first.

While the third byte goes out, the target should return the second instruction byte. The block captures that byte and compares it with the second byte it sent. The comparison decides nothing until all four bytes have gone out. A match ends the sequence with `done`. A mismatch starts a new attempt with a fresh reset pulse. When the attempt limit is used up with no match, the block raises `fail` instead.

The serial clock half-period is set in system clocks by a parameter. The settling time is also a parameter, so a simulation can shorten the long power-up wait.

Top module: `spi_prog_enable`

## Requirements
- R1: While `rst_n` is low, `tgt_rst`, `sck`, `mosi`, `done` and `fail` are all 0.
- R2: A `start` sampled high while idle, done or failed begins an attempt. In each attempt `tgt_rst` is high for exactly `RST_PULSE_CYC` cycles, and `sck` stays low the whole time.
- R3: After the reset pulse falls, `tgt_rst` and `sck` stay low for `SETTLE_CYC` cycles of settling plus one low half-period. The first rising edge of `sck` comes exactly `SETTLE_CYC + CLK_DIV` cycles after the fall.
- R4: `sck` is low for `CLK_DIV` cycles and then high for `CLK_DIV` cycles on every bit (`CLK_DIV` >= 4). `mosi` changes only while `sck` is low.
- R5: Each attempt sends `CMD0`, `CMD1`, `CMD2`, `CMD3` in that order, most significant bit first. The defaults are 0xAC, 0x53, 0x00, 0x00.
- R6: `miso` is sampled on each rising edge of `sck`. The byte received during the third byte sent is compared with `CMD1`.
- R7: Every attempt produces exactly 32 rising edges of `sck`, whether the comparison passes or not.
- R8: When an attempt's comparison fails and attempts remain, a new reset pulse follows and the instruction is sent again.
- R9: When the comparison passes, `done` goes high after the fourth byte. It stays high with `sck` and `tgt_rst` low until the next `start`.
- R10: When `MAX_TRIES` attempts have all failed, `fail` goes high. It stays high with no further `sck` or `tgt_rst` activity until the next `start`.
- R11: `start` has no effect while an attempt is running. `done` and `fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the entry sequence |
| miso | input | 1 | Serial data from target |
| tgt_rst | output | 1 | Target reset drive, high = reset pulse |
| sck | output | 1 | Serial clock to target |
| mosi | output | 1 | Serial data to target |
| done | output | 1 | Target acknowledged the enable instruction |
| fail | output | 1 | Attempt limit reached without acknowledgement |

## Verification
The checker assumes only that `miso` and `start` are synchronous to `clk`. It assumes nothing about their values: `start` may arrive in any state, and `miso` may carry any pattern. The bench target model changes `miso` only on falling edges of the system clock. It starts to echo correctly only after a chosen number of failed attempts. This covers first-try success, success after retries, and exhaustion of the limit. Start requests are always single cycles and reach a busy block only in the directed test.

// File: rtl/spi_prog_enable.sv
module spi_prog_enable #(
  parameter int unsigned CLK_DIV       = 8,
  parameter int unsigned RST_PULSE_CYC = 4,
  parameter int unsigned SETTLE_CYC    = 320000,
  parameter int unsigned MAX_TRIES     = 32,
  parameter logic [7:0]  CMD0          = 8'hAC,
  parameter logic [7:0]  CMD1          = 8'h53,
  parameter logic [7:0]  CMD2          = 8'h00,
  parameter logic [7:0]  CMD3          = 8'h00
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic miso,
  output logic tgt_rst,
  output logic sck,
  output logic mosi,
  output logic done,
  output logic fail
);

  localparam int unsigned TMAX = (SETTLE_CYC > RST_PULSE_CYC)
                                 ? ((SETTLE_CYC > CLK_DIV) ? SETTLE_CYC : CLK_DIV)
                                 : ((RST_PULSE_CYC > CLK_DIV) ? RST_PULSE_CYC : CLK_DIV);
  localparam int unsigned TW = $clog2(TMAX + 1);
  localparam int unsigned NW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_PULSE, S_SETTLE, S_LOW, S_HIGH, S_DONE, S_FAIL
  } st_t;

  st_t            state;
  logic [TW-1:0]  tmr;
  logic [2:0]     bitn;
  logic [1:0]     byten;
  logic [NW-1:0]  tries;
  logic [7:0]     sh, rx, nxt_cmd;
  logic           echo_ok;

  wire idle_like = (state == S_IDLE) || (state == S_DONE) || (state == S_FAIL);
  wire half_end  = (tmr == TW'(CLK_DIV - 1));

  always_comb
    case (byten)
      2'd0:    nxt_cmd = CMD1;
      2'd1:    nxt_cmd = CMD2;
      default: nxt_cmd = CMD3;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= S_IDLE;
      tmr     <= '0;
      bitn    <= '0;
      byten   <= '0;
      tries   <= '0;
      sh      <= '0;
      rx      <= '0;
      echo_ok <= 1'b0;
    end else begin
      case (state)
        S_PULSE:
          if (tmr == TW'(RST_PULSE_CYC - 1)) begin
            tmr   <= '0;
            state <= S_SETTLE;
          end else tmr <= tmr + 1'b1;
        S_SETTLE:
          if (tmr == TW'(SETTLE_CYC - 1)) begin
            tmr     <= '0;
            bitn    <= '0;
            byten   <= '0;
            sh      <= CMD0;
            echo_ok <= 1'b0;
            state   <= S_LOW;
          end else tmr <= tmr + 1'b1;
        S_LOW:
          if (half_end) begin
            tmr   <= '0;
            rx    <= {rx[6:0], miso};
            state <= S_HIGH;
          end else tmr <= tmr + 1'b1;
        S_HIGH:
          if (half_end) begin
            tmr <= '0;
            if (bitn != 3'd7) begin
              bitn  <= bitn + 1'b1;
              sh    <= {sh[6:0], 1'b0};
              state <= S_LOW;
            end else begin
              bitn <= '0;
              if (byten == 2'd2) echo_ok <= (rx == CMD1);
              if (byten == 2'd3) begin
                if (echo_ok)                         state <= S_DONE;
                else if (tries == NW'(MAX_TRIES - 1)) state <= S_FAIL;
                else begin
                  tries <= tries + 1'b1;
                  state <= S_PULSE;
                end
              end else begin
                byten <= byten + 1'b1;
                sh    <= nxt_cmd;
                state <= S_LOW;
              end
            end
          end else tmr <= tmr + 1'b1;
        default:
          if (idle_like && start) begin
            tmr   <= '0;
            tries <= '0;
            state <= S_PULSE;
          end
      endcase
    end

  assign tgt_rst = (state == S_PULSE);
  assign sck     = (state == S_HIGH);
  assign mosi    = ((state == S_LOW) || (state == S_HIGH)) && sh[7];
  assign done    = (state == S_DONE);
  assign fail    = (state == S_FAIL);

endmodule

module spi_prog_enable_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic tgt_rst,
  input logic sck,
  input logic mosi,
  input logic done,
  input logic fail
);
  AST_PULSE_SCK_LOW:  assert property (@(posedge clk) disable iff (!rst_n) tgt_rst |-> !sck);                 // R2
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (sck && $past(sck)) |-> $stable(mosi)); // R4
  AST_SCK_HIGH_MIN:   assert property (@(posedge clk) disable iff (!rst_n) $rose(sck) |=> sck);               // R4
  AST_SCK_LOW_MIN:    assert property (@(posedge clk) disable iff (!rst_n) $fell(sck) |=> !sck);              // R4
  AST_STATUS_EXCL:    assert property (@(posedge clk) disable iff (!rst_n) !(done && fail));                  // R11
  AST_DONE_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> done);        // R9
  AST_DONE_QUIET:     assert property (@(posedge clk) disable iff (!rst_n) done |-> (!sck && !tgt_rst));      // R9
  AST_FAIL_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) (fail && !start) |=> fail);        // R10
  AST_FAIL_QUIET:     assert property (@(posedge clk) disable iff (!rst_n) fail |-> (!sck && !tgt_rst));      // R10
endmodule

bind spi_prog_enable spi_prog_enable_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tgt_rst(tgt_rst),
  .sck(sck), .mosi(mosi), .done(done), .fail(fail)
);

// File: tb/test_spi_prog_enable.sv
module test_spi_prog_enable;
  localparam int CLK_P  = 10;
  localparam int DIV    = 4;
  localparam int PULSE  = 3;
  localparam int SETTLE = 20;
  localparam int TRIES  = 3;

  // bad attempts before echo is correct, expect done, expected attempts
  localparam int VEC [5][3] = '{'{0,1,1}, '{1,1,2}, '{2,1,3}, '{3,0,3}, '{0,1,1}};

  logic clk = 0, rst_n = 0, start = 0;
  logic tgt_rst, sck, mosi, done, fail, miso;
  int n_run = 0, n_fail = 0;

  spi_prog_enable #(.CLK_DIV(DIV), .RST_PULSE_CYC(PULSE), .SETTLE_CYC(SETTLE), .MAX_TRIES(TRIES))
    i_spi_prog_enable (.clk(clk), .rst_n(rst_n), .start(start), .miso(miso),
                       .tgt_rst(tgt_rst), .sck(sck), .mosi(mosi), .done(done), .fail(fail));

  always #(CLK_P/2) clk = ~clk;

  // target model and monitor
  logic [7:0] sent [4];
  logic [7:0] cur = 0, prevb = 0;
  int bitc = 0, attempt = 0, bad_n = 0;
  int pulses = 0, rises = 0, plen = 0, last_plen = 0, gap = 0, last_gap = 0;
  int hi_run = 0, lo_run = 0, tbad = 0, mosi_bad = 0;
  bit gapping = 0;
  logic p_sck = 0, p_rst = 0, p_mosi = 0;
  wire [2:0] bix = 3'd7 - bitc[2:0];
  assign miso = (attempt > bad_n) ? prevb[bix] : ~prevb[bix];

  always @(negedge clk) begin
    if (tgt_rst && !p_rst) begin
      pulses++; attempt++; bitc = 0; prevb = 0; plen = 0;
    end
    if (tgt_rst) plen++;
    if (!tgt_rst && p_rst) begin last_plen = plen; gap = 0; gapping = 1; end
    if (gapping && !sck) gap++;
    if (sck && p_sck && mosi != p_mosi) mosi_bad++;
    if (sck) hi_run++;
    if (!sck && !tgt_rst && !gapping) lo_run++;
    if (!sck && p_sck) begin
      if (hi_run != DIV) tbad++;
      hi_run = 0; lo_run = 1;
    end
    if (sck && !p_sck) begin
      if (gapping) begin last_gap = gap; gapping = 0; end
      else if (lo_run != DIV) tbad++;
      lo_run = 0; hi_run = 1;
      rises++;
      cur = {cur[6:0], mosi};
      if (bitc < 32) sent[bitc/8][7 - bitc%8] = mosi;
      bitc++;
      if (bitc % 8 == 0) prevb = cur;
    end
    p_sck = sck; p_rst = tgt_rst; p_mosi = mosi;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic clear_mon(input int bad);
    bad_n = bad; attempt = 0; pulses = 0; rises = 0; tbad = 0; mosi_bad = 0;
    last_plen = 0; last_gap = 0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 4000 && !(done || fail); i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({tgt_rst, sck, mosi, done, fail} == 5'b0, "R1", {tgt_rst, sck, mosi, done, fail}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk({tgt_rst, sck, done, fail} == 4'b0, "R1 idle", {tgt_rst, sck, done, fail}, 0);

    for (int v = 0; v < 5; v++) begin
      clear_mon(VEC[v][0]);
      pulse_start();
      wait_end();
      chk(done == VEC[v][1][0], "R9 done", done, VEC[v][1]);
      chk(fail == !VEC[v][1][0], "R10 fail", fail, !VEC[v][1][0]);
      chk(pulses == VEC[v][2], "R8/R6 attempts", pulses, VEC[v][2]);
      chk(rises == 32 * VEC[v][2], "R7 edges", rises, 32 * VEC[v][2]);
      chk({sent[0], sent[1], sent[2], sent[3]} == 32'hAC530000, "R5 bytes",
          {sent[0], sent[1], sent[2], sent[3]}, 32'hAC530000);
      chk(last_plen == PULSE, "R2 pulse", last_plen, PULSE);
      chk(last_gap == SETTLE + DIV, "R3 settle", last_gap, SETTLE + DIV);
      chk(tbad == 0 && mosi_bad == 0, "R4 timing", tbad + mosi_bad, 0);
    end

    // R9: done held, no further activity
    rises = 0; pulses = 0;
    repeat (40) @(negedge clk);
    chk(done && !fail && rises == 0 && pulses == 0, "R9 hold", rises + pulses, 0);

    // R11: start while busy is ignored
    clear_mon(0);
    pulse_start();
    repeat (60) @(negedge clk);
    chk(!done && !fail, "R11 busy", done, 0);
    pulse_start();
    wait_end();
    chk(pulses == 1 && rises == 32, "R11 restart ignored", pulses, 1);
    chk(done, "R11 result", done, 1);

    // R10: fail held after exhaustion
    clear_mon(99);
    pulse_start();
    wait_end();
    rises = 0; pulses = 0;
    repeat (40) @(negedge clk);
    chk(fail && !done && rises == 0 && pulses == 0, "R10 hold", fail, 1);
    chk(!(done && fail), "R11 excl", done & fail, 0);

    finish_run();
  end
endmodule